// File: doc/BRIEF.md
# Hash DRBG Operation Sequencer

This block is the control and state-holding core of a hash-based deterministic random bit generator. It accepts three commands (instantiate, reseed and generate), owns the working value V, the constant C, the reseed counter and the captured seed material, and carries out each command as a fixed series of steps. Each step goes through one shared external hash port (a 512-bit block in, a 256-bit digest back after a fixed latency) and one shared multi-cycle serial adder. Output words of 256 bits leave through a valid/ready stream.

Every wide addition is launched in the same cycle as the hash call it can run beside. The increment of the generate counter overlaps the hash of each output word, and the addition of C overlaps the final hash of a request. When the consumer holds `out_ready` low, the sequencer keeps the current word on `out_data` with `out_valid` high and starts no further hash call until the word is taken. No word is dropped or duplicated. Commands, the seed inputs and the error flags are plain pins.

Top module: `drbg_seq`

## Requirements
- R1: After reset, `busy`, `out_valid`, `hash_start`, `err_uninit` and `err_reseed` are low, and the generator counts as not instantiated.
- R2: A command is taken when `cmd_valid` is high while `busy` is low. `cmd_op` is 0 for instantiate, 1 for reseed, 2 for generate, and 3 is ignored. `busy` is high from the cycle after acceptance until the operation ends. A command presented while `busy` is high has no effect, and its `entropy_in` and `pers_in` are not captured.
- R3: Generate or reseed before a completed instantiate is refused. `err_uninit` pulses high for exactly one cycle after the command edge, and `busy` stays low.
- R4: Instantiate captures `entropy_in` (E) and `pers_in` (P) and makes four hash calls with tag t = 0..3. Each block is E XOR {M, 64 zero bits, t as an 8-bit value}. For t = 0 and 1, M is P placed in the top 128 of 440 bits. For t = 2 and 3, M is the new V. The new V is the low 440 bits of {D1, D0}, C is the low 440 bits of {D3, D2}, and the counter becomes 1.
- R5: Reseed follows R4, except that M for t = 0 and 1 is the V held before the reseed, and `pers_in` is ignored. It also sets the counter to 1.
- R6: Generate with N = `cmd_words` sets a working value W = V. For each word k it outputs H({W, 64 zero bits, 8'h02}) and then sets W = W + 1 mod 2^440. Exactly N words are delivered, and N = 0 is allowed.
- R7: After the words of a generate, the block sets V = (V + H({V, 64 zero bits, 8'h03}) + C + counter) mod 2^440, using the counter value before the request, and then increments the counter.
- R8: Generate with the counter at its all-ones value is refused. `err_reseed` pulses for one cycle and `busy` stays low. A reseed clears the condition.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value. A word counts as delivered on a cycle where both are high.
- R10: `hash_start` pulses only while `busy` is high, and never while an earlier call still awaits `hash_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code (0 instantiate, 1 reseed, 2 generate) |
| cmd_words | input | WRD_W | Words requested by a generate |
| entropy_in | input | BLK_W | Entropy block, captured on instantiate or reseed |
| pers_in | input | PERS_W | Personalization value, captured on instantiate |
| busy | output | 1 | Operation in progress |
| err_uninit | output | 1 | One-cycle pulse: refused, not instantiated |
| err_reseed | output | 1 | One-cycle pulse: refused, reseed needed |
| hash_start | output | 1 | Launches a hash call |
| hash_block | output | BLK_W | Message block for the hash call |
| hash_done | input | 1 | Digest ready pulse |
| hash_digest | input | DIG_W | Digest of the last block |
| out_valid | output | 1 | Output word valid |
| out_data | output | DIG_W | Output word |
| out_ready | input | 1 | Consumer ready |

## Verification
The bench keeps the 440-bit V, C and 512-bit block widths at their defaults, so the arithmetic and truncation are checked at full size with carries across all eleven adder digits. It shrinks the reseed counter to 3 bits. The all-ones refusal then comes after six generates, and a reseed can be shown to clear it. A stub hash with the full 64-cycle latency makes the adder overlap and the output back-pressure, both steady and long stalls, observable within a short run.

// File: rtl/drbg_pkg.sv
package drbg_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_SEED_GO, S_SEED_WT, S_WORD_GO, S_WORD_WT,
    S_FIN_GO, S_FIN_WT, S_ADH_GO, S_ADH_WT, S_ADN_GO, S_ADN_WT
  } seq_state_e;

  typedef enum logic [1:0] { BK_SEED, BK_WORD, BK_FINAL } blk_kind_e;

  typedef enum logic [1:0] { AB_ONE, AB_C, AB_DIG, AB_CNT } addb_sel_e;

  localparam logic [1:0] OPC_INST   = 2'd0;
  localparam logic [1:0] OPC_RESEED = 2'd1;
  localparam logic [1:0] OPC_GEN    = 2'd2;

  localparam logic [7:0] TAG_WORD  = 8'h02;
  localparam logic [7:0] TAG_FINAL = 8'h03;

endpackage

// File: rtl/drbg_serial_add.sv
module drbg_serial_add #(
  parameter int W   = 440,
  parameter int DIG = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         done,
  output logic [W-1:0] sum
);
  localparam int NDIG = W / DIG;
  localparam int CW   = $clog2(NDIG + 1);

  logic [W-1:0]  acc_q, bop_q;
  logic          cy_q, run_q;
  logic [CW-1:0] left_q;
  logic [DIG:0]  dsum;

  // one digit per cycle, the running sum rotates through the accumulator
  always_comb dsum = {1'b0, acc_q[DIG-1:0]} + {1'b0, bop_q[DIG-1:0]} + (DIG+1)'(cy_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      bop_q  <= '0;
      cy_q   <= 1'b0;
      run_q  <= 1'b0;
      left_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        acc_q  <= a;
        bop_q  <= b;
        cy_q   <= 1'b0;
        run_q  <= 1'b1;
        left_q <= CW'(NDIG);
      end else if (run_q) begin
        acc_q  <= {dsum[DIG-1:0], acc_q[W-1:DIG]};
        bop_q  <= bop_q >> DIG;
        cy_q   <= dsum[DIG];
        left_q <= left_q - 1'b1;
        if (left_q == CW'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  assign sum = acc_q;
endmodule

// File: rtl/drbg_route.sv
module drbg_route
  import drbg_pkg::*;
#(
  parameter int VLEN   = 440,
  parameter int PERS_W = 128,
  parameter int BLK_W  = 512,
  parameter int DIG_W  = 256,
  parameter int CTR_W  = 20
) (
  input  blk_kind_e         kind,
  input  logic [1:0]        tag,
  input  logic              use_pers,
  input  logic [BLK_W-1:0]  ent,
  input  logic [PERS_W-1:0] pers,
  input  logic [VLEN-1:0]   v,
  input  logic [VLEN-1:0]   data,
  input  logic [VLEN-1:0]   c,
  input  logic [DIG_W-1:0]  dig,
  input  logic [CTR_W-1:0]  cnt,
  input  addb_sel_e         bsel,
  output logic [BLK_W-1:0]  blk,
  output logic [VLEN-1:0]   addb
);
  localparam int PAD = BLK_W - VLEN - 8;

  logic [VLEN-1:0] mix;

  always_comb begin
    mix = use_pers ? {pers, {(VLEN-PERS_W){1'b0}}} : v;
    unique case (kind)
      BK_SEED: blk = ent ^ {mix, {PAD{1'b0}}, 6'b0, tag};
      BK_WORD: blk = {data, {PAD{1'b0}}, TAG_WORD};
      default: blk = {v, {PAD{1'b0}}, TAG_FINAL};
    endcase
  end

  always_comb begin
    unique case (bsel)
      AB_ONE:  addb = VLEN'(1);
      AB_C:    addb = c;
      AB_DIG:  addb = VLEN'(dig);
      default: addb = VLEN'(cnt);
    endcase
  end
endmodule

// File: rtl/drbg_seq.sv
module drbg_seq
  import drbg_pkg::*;
#(
  parameter int VLEN    = 440,
  parameter int PERS_W  = 128,
  parameter int BLK_W   = 512,
  parameter int DIG_W   = 256,
  parameter int CTR_W   = 20,
  parameter int WRD_W   = 8,
  parameter int ADD_DIG = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [WRD_W-1:0]  cmd_words,
  input  logic [BLK_W-1:0]  entropy_in,
  input  logic [PERS_W-1:0] pers_in,
  output logic              busy,
  output logic              err_uninit,
  output logic              err_reseed,
  output logic              hash_start,
  output logic [BLK_W-1:0]  hash_block,
  input  logic              hash_done,
  input  logic [DIG_W-1:0]  hash_digest,
  output logic              out_valid,
  output logic [DIG_W-1:0]  out_data,
  input  logic              out_ready
);
  seq_state_e        st_q;
  logic [VLEN-1:0]   v_q, c_q, data_q;
  logic [CTR_W-1:0]  cnt_q;
  logic [BLK_W-1:0]  ent_q;
  logic [PERS_W-1:0] pers_q;
  logic [DIG_W-1:0]  lo_q, hreg_q;
  logic [WRD_W-1:0]  words_q;
  logic [1:0]        tag_q;
  logic              is_inst_q, inst_ok_q, h_pend_q, a_pend_q;

  blk_kind_e         kind;
  addb_sel_e         bsel;
  logic [BLK_W-1:0]  rt_blk;
  logic [VLEN-1:0]   add_a, add_b, add_sum;
  logic              add_start, add_done;

  always_comb begin
    unique case (st_q)
      S_SEED_GO: kind = BK_SEED;
      S_WORD_GO: kind = BK_WORD;
      default:   kind = BK_FINAL;
    endcase
    unique case (st_q)
      S_WORD_GO: bsel = AB_ONE;
      S_FIN_GO:  bsel = AB_C;
      S_ADH_GO:  bsel = AB_DIG;
      default:   bsel = AB_CNT;
    endcase
    add_a     = (st_q == S_WORD_GO) ? data_q : v_q;
    add_start = (st_q == S_WORD_GO) || (st_q == S_FIN_GO) ||
                (st_q == S_ADH_GO)  || (st_q == S_ADN_GO);
  end

  drbg_route #(
    .VLEN(VLEN), .PERS_W(PERS_W), .BLK_W(BLK_W), .DIG_W(DIG_W), .CTR_W(CTR_W)
  ) route_i (
    .kind(kind), .tag(tag_q), .use_pers(is_inst_q && !tag_q[1]),
    .ent(ent_q), .pers(pers_q), .v(v_q), .data(data_q), .c(c_q),
    .dig(hreg_q), .cnt(cnt_q), .bsel(bsel), .blk(rt_blk), .addb(add_b)
  );

  drbg_serial_add #(.W(VLEN), .DIG(ADD_DIG)) adder_i (
    .clk(clk), .rst_n(rst_n), .start(add_start), .a(add_a), .b(add_b),
    .done(add_done), .sum(add_sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      v_q        <= '0;
      c_q        <= '0;
      data_q     <= '0;
      cnt_q      <= '0;
      ent_q      <= '0;
      pers_q     <= '0;
      lo_q       <= '0;
      hreg_q     <= '0;
      words_q    <= '0;
      tag_q      <= '0;
      is_inst_q  <= 1'b0;
      inst_ok_q  <= 1'b0;
      h_pend_q   <= 1'b0;
      a_pend_q   <= 1'b0;
      err_uninit <= 1'b0;
      err_reseed <= 1'b0;
      hash_start <= 1'b0;
      hash_block <= '0;
      out_valid  <= 1'b0;
      out_data   <= '0;
    end else begin
      err_uninit <= 1'b0;
      err_reseed <= 1'b0;
      hash_start <= 1'b0;
      unique case (st_q)
        S_IDLE: if (cmd_valid) begin
          if (cmd_op == OPC_INST) begin
            ent_q     <= entropy_in;
            pers_q    <= pers_in;
            is_inst_q <= 1'b1;
            tag_q     <= 2'd0;
            st_q      <= S_SEED_GO;
          end else if (cmd_op == OPC_RESEED) begin
            if (!inst_ok_q) err_uninit <= 1'b1;
            else begin
              ent_q     <= entropy_in;
              is_inst_q <= 1'b0;
              tag_q     <= 2'd0;
              st_q      <= S_SEED_GO;
            end
          end else if (cmd_op == OPC_GEN) begin
            if (!inst_ok_q) err_uninit <= 1'b1;
            else if (&cnt_q) err_reseed <= 1'b1;
            else begin
              data_q  <= v_q;
              words_q <= cmd_words;
              st_q    <= (cmd_words == '0) ? S_FIN_GO : S_WORD_GO;
            end
          end
        end
        S_SEED_GO: begin
          hash_start <= 1'b1;
          hash_block <= rt_blk;
          st_q       <= S_SEED_WT;
        end
        S_SEED_WT: if (hash_done) begin
          unique case (tag_q)
            2'd1: v_q <= VLEN'({hash_digest, lo_q});
            2'd3: begin
              c_q       <= VLEN'({hash_digest, lo_q});
              cnt_q     <= CTR_W'(1);
              inst_ok_q <= 1'b1;
            end
            default: lo_q <= hash_digest;
          endcase
          tag_q <= tag_q + 2'd1;
          st_q  <= (tag_q == 2'd3) ? S_IDLE : S_SEED_GO;
        end
        S_WORD_GO, S_FIN_GO: begin
          hash_start <= 1'b1;
          hash_block <= rt_blk;
          h_pend_q   <= 1'b1;
          a_pend_q   <= 1'b1;
          st_q       <= (st_q == S_WORD_GO) ? S_WORD_WT : S_FIN_WT;
        end
        S_WORD_WT: begin
          if (hash_done) begin
            out_data  <= hash_digest;
            out_valid <= 1'b1;
            h_pend_q  <= 1'b0;
          end
          if (add_done) begin
            data_q   <= add_sum;
            a_pend_q <= 1'b0;
          end
          if (out_valid && out_ready) begin
            out_valid <= 1'b0;
            words_q   <= words_q - 1'b1;
          end
          if (!h_pend_q && !a_pend_q && !out_valid)
            st_q <= (words_q == '0) ? S_FIN_GO : S_WORD_GO;
        end
        S_FIN_WT: begin
          if (hash_done) begin
            hreg_q   <= hash_digest;
            h_pend_q <= 1'b0;
          end
          if (add_done) begin
            v_q      <= add_sum;
            a_pend_q <= 1'b0;
          end
          if (!h_pend_q && !a_pend_q) st_q <= S_ADH_GO;
        end
        S_ADH_GO: st_q <= S_ADH_WT;
        S_ADH_WT: if (add_done) begin
          v_q  <= add_sum;
          st_q <= S_ADN_GO;
        end
        S_ADN_GO: st_q <= S_ADN_WT;
        S_ADN_WT: if (add_done) begin
          v_q   <= add_sum;
          cnt_q <= cnt_q + 1'b1;
          st_q  <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy = (st_q != S_IDLE);
endmodule

// File: rtl/drbg_seq_chk.sv
module drbg_seq_chk #(
  parameter int DIG_W = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             err_uninit,
  input logic             err_reseed,
  input logic             hash_start,
  input logic             hash_done,
  input logic             out_valid,
  input logic             out_ready,
  input logic [DIG_W-1:0] out_data
);
  logic call_open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) call_open_q <= 1'b0;
    else if (hash_start) call_open_q <= 1'b1;
    else if (hash_done) call_open_q <= 1'b0;
  end

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9
  out_in_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

  // R10
  hash_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hash_start |-> !call_open_q);

  // R10
  hash_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hash_start |-> busy);

  // R3
  refuse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_uninit || err_reseed) |-> !busy);

  // R3
  refuse_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_uninit |=> !err_uninit);

  // R8
  reseed_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_reseed |=> !err_reseed);
endmodule

bind drbg_seq drbg_seq_chk #(.DIG_W(DIG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .err_uninit(err_uninit),
  .err_reseed(err_reseed), .hash_start(hash_start), .hash_done(hash_done),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/drbg_seq_tb.sv
module drbg_seq_tb_top;
  localparam int VLEN = 440, PERS_W = 128, BLK_W = 512, DIG_W = 256;
  localparam int CTR_W = 3, WRD_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [WRD_W-1:0] cmd_words = '0;
  logic [BLK_W-1:0] entropy_in = '0;
  logic [PERS_W-1:0] pers_in = '0;
  logic busy, err_uninit, err_reseed, hash_start, hash_done, out_valid;
  logic out_ready = 1'b0;
  logic [BLK_W-1:0] hash_block;
  logic [DIG_W-1:0] hash_digest, out_data;

  int n_run = 0, n_fail = 0;

  logic [VLEN-1:0] mv, mc;
  logic [CTR_W-1:0] mcnt;

  always #5 clk = ~clk;

  drbg_seq #(.VLEN(VLEN), .PERS_W(PERS_W), .BLK_W(BLK_W), .DIG_W(DIG_W),
             .CTR_W(CTR_W), .WRD_W(WRD_W), .ADD_DIG(40)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_words(cmd_words), .entropy_in(entropy_in), .pers_in(pers_in),
    .busy(busy), .err_uninit(err_uninit), .err_reseed(err_reseed),
    .hash_start(hash_start), .hash_block(hash_block), .hash_done(hash_done),
    .hash_digest(hash_digest), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready)
  );

  function automatic logic [DIG_W-1:0] hfn(input logic [BLK_W-1:0] b);
    return (b[511:256] ^ {b[127:0], b[255:128]}) + 256'h9e3779b97f4a7c15;
  endfunction

  // hash stub: fixed 64-cycle latency
  logic [BLK_W-1:0] sb;
  int sc;
  always @(posedge clk) begin
    if (!rst_n) begin
      hash_done <= 1'b0; sc <= 0; hash_digest <= '0;
    end else begin
      hash_done <= 1'b0;
      if (hash_start) begin
        sb <= hash_block; sc <= 64;
      end else if (sc != 0) begin
        sc <= sc - 1;
        if (sc == 1) begin hash_done <= 1'b1; hash_digest <= hfn(sb); end
      end
    end
  end

  task automatic chk(input logic ok, input string req, input logic [DIG_W-1:0] act,
                     input logic [DIG_W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input int nw);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_words = WRD_W'(nw);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // R4 / R5 model
  task automatic model_seed(input logic [BLK_W-1:0] e, input logic [PERS_W-1:0] p,
                            input logic inst);
    logic [VLEN-1:0] m;
    logic [DIG_W-1:0] d0, d1, d2, d3;
    m  = inst ? {p, {(VLEN-PERS_W){1'b0}}} : mv;
    d0 = hfn(e ^ {m, 64'b0, 8'd0});
    d1 = hfn(e ^ {m, 64'b0, 8'd1});
    mv = VLEN'({d1, d0});
    d2 = hfn(e ^ {mv, 64'b0, 8'd2});
    d3 = hfn(e ^ {mv, 64'b0, 8'd3});
    mc = VLEN'({d3, d2});
    mcnt = CTR_W'(1);
  endtask

  task automatic t_seed(input logic inst, input logic [BLK_W-1:0] e,
                        input logic [PERS_W-1:0] p, input string req);
    entropy_in = e; pers_in = p;
    issue(inst ? 2'd0 : 2'd1, 0);
    chk(busy === 1'b1, {req, " busy after accept (R2)"}, DIG_W'(busy), 1);
    wait_idle();
    model_seed(e, p, inst);
  endtask

  // R6 / R7 / R9: generate with a ready pattern
  task automatic t_gen(input int n, input int mode, input string req);
    logic [DIG_W-1:0] ew [16];
    logic [VLEN-1:0] d;
    logic [DIG_W-1:0] hf, held;
    logic hold;
    int idx, cyc;
    d = mv;
    for (int k = 0; k < n; k++) begin
      ew[k] = hfn({d, 64'b0, 8'h02});
      d = d + VLEN'(1);
    end
    hf = hfn({mv, 64'b0, 8'h03});
    issue(2'd2, n);
    chk(busy === 1'b1, {req, " busy during generate (R2)"}, DIG_W'(busy), 1);
    idx = 0; cyc = 0; hold = 1'b0; held = '0;
    while (busy) begin
      case (mode)
        0: out_ready = 1'b1;
        1: out_ready = (cyc % 4 == 3);
        default: out_ready = (cyc > 150);
      endcase
      if (hold && out_valid)
        chk(out_data === held, {req, " held word (R9)"}, out_data, held);
      if (out_valid && out_ready) begin
        chk(idx < n && out_data === ew[idx], {req, " word (R6)"}, out_data,
            idx < n ? ew[idx] : '0);
        idx++;
      end
      hold = out_valid && !out_ready;
      held = out_data;
      cyc++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(idx == n, {req, " word count (R6)"}, DIG_W'(idx), DIG_W'(n));
    mv = mv + VLEN'(hf) + mc + VLEN'(mcnt);
    mcnt = mcnt + 1'b1;
  endtask

  task automatic t_refused(input logic [1:0] op, input logic want_reseed, input string req);
    issue(op, 1);
    chk(busy === 1'b0, {req, " busy stays low"}, DIG_W'(busy), 0);
    chk((want_reseed ? err_reseed : err_uninit) === 1'b1, {req, " flag set"},
        DIG_W'(want_reseed ? err_reseed : err_uninit), 1);
    @(negedge clk);
    chk(err_uninit === 1'b0 && err_reseed === 1'b0, {req, " flag is one pulse"},
        DIG_W'({err_uninit, err_reseed}), 0);
  endtask

  task automatic t_reset();
    chk(busy === 1'b0 && out_valid === 1'b0 && hash_start === 1'b0 &&
        err_uninit === 1'b0 && err_reseed === 1'b0, "R1 reset outputs",
        DIG_W'({busy, out_valid, hash_start, err_uninit, err_reseed}), 0);
  endtask

  // R2: commands during an operation are ignored
  task automatic t_busy_ignore();
    logic [VLEN-1:0] d;
    logic [DIG_W-1:0] hf, w0;
    d = mv;
    w0 = hfn({d, 64'b0, 8'h02});
    hf = hfn({mv, 64'b0, 8'h03});
    out_ready = 1'b1;
    issue(2'd2, 1);
    repeat (5) @(negedge clk);
    entropy_in = {16{32'hdeadbeef}}; pers_in = '1;
    cmd_valid = 1'b1; cmd_op = 2'd0;
    @(negedge clk);
    cmd_op = 2'd1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) begin
      if (out_valid) chk(out_data === w0, "R2 word during ignored cmds", out_data, w0);
      @(negedge clk);
    end
    out_ready = 1'b0;
    mv = mv + VLEN'(hf) + mc + VLEN'(mcnt);
    mcnt = mcnt + 1'b1;
    t_gen(1, 0, "R2 state untouched by ignored cmds");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog (R2) actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    mv = '0; mc = '0; mcnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_refused(2'd2, 1'b0, "R3 generate before instantiate");
    t_refused(2'd1, 1'b0, "R3 reseed before instantiate");
    issue(2'd3, 0);
    chk(busy === 1'b0, "R2 code 3 ignored", DIG_W'(busy), 0);
    t_seed(1'b1, {16{32'h01234567}} ^ 512'h5a, 128'hfeedface_c0ffee00_11223344_55667788,
           "R4 instantiate");
    t_gen(3, 0, "R6 R7 steady ready");
    t_gen(2, 1, "R9 sparse ready");
    t_gen(0, 0, "R6 zero words");
    t_gen(1, 2, "R9 long stall");
    t_seed(1'b0, {8{64'h0f1e2d3c4b5a6978}}, 128'h0, "R5 reseed");
    t_gen(2, 0, "R5 after reseed");
    t_busy_ignore();
    t_seed(1'b1, {16{32'hffff0000}}, 128'h1, "R4 second instantiate");
    while (mcnt != '1) t_gen(0, 0, "R7 counter advance");
    t_refused(2'd2, 1'b1, "R8 counter exhausted");
    t_seed(1'b0, {16{32'h13579bdf}}, 128'h0, "R8 reseed clears");
    t_gen(2, 0, "R8 generate after reseed");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule